// File: doc/BRIEF.md
# Triggered Delay-and-Width Pulse Timer

This block turns an edge on an external trigger pin into one timed output pulse. After a rising edge on the trigger, the output stays low for a programmed number of time-base ticks. It then goes high for a second programmed number of ticks and returns to idle. Software sets the delay, the width and the control bits through a small register port.

The time base is selected by a control bit. It is either a one-cycle microsecond strobe from elsewhere in the chip, or the rising edges of an external clock pin. That external clock is synchronized inside the block.

Three interrupt causes can each be enabled on their own:
- the trigger being accepted;
- the output rising;
- the output falling.

Any enabled cause produces a one-cycle interrupt pulse. None of the interfaces carries a data stream, so there is no valid/ready handshake and no back-pressure. The register port accepts a write on every cycle that `reg_wr` is high, and its read data is combinational from `reg_addr`.

Top module: `trig_pulse_timer`

## Requirements
- R1: After reset `pulse_out` and `irq` are low, and all control, delay and width registers read as zero.
- R2: Register map, selected by `reg_addr`:
  - Address 0 is control: bit 0 enables the block, bit 1 selects the time base (0 = `tick_us`, 1 = external clock), and bits 4:2 enable the interrupts (bit 2 trigger, bit 3 rise, bit 4 fall). Bits 15:5 read as zero.
  - Address 1 holds the delay and address 2 holds the width.
  - Address 3 reads as zero.
  - A value written to addresses 0 to 2 is returned on a read of the same address.
- R3: When enabled and idle, a rising edge on `trig_in`, after a two-flop synchronizer, starts a sequence. `pulse_out` rises on tick number delay+1 after the trigger, so a delay of 0 starts the pulse on the next tick.
- R4: `pulse_out` stays high for width ticks (one tick when the width is 0), then falls, and the block returns to idle.
- R5: With the time-base bit at 0 only `tick_us` advances the count. With the bit at 1 only synchronized rising edges of `ext_clk` advance it, and `tick_us` is ignored.
- R6: A trigger edge that arrives while a sequence is running has no effect on the timing.
- R7: Each enabled event (trigger accepted, output rise, output fall) drives `irq` high for one cycle, in the same cycle as the matching state change. Disabled events give no pulse.
- R8: Clearing the enable bit returns the block to idle with `pulse_out` low on the next cycle and no fall interrupt. While the block is disabled, triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| tick_us | input | 1 | One-cycle microsecond strobe time base |
| trig_in | input | 1 | Asynchronous trigger input |
| ext_clk | input | 1 | Asynchronous external time-base clock |
| pulse_out | output | 1 | Delayed output pulse |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that `trig_in` and `ext_clk` stay at each level for at least two clock cycles, so that every synchronized edge is seen exactly once. The stimulus holds every level of those pins for four cycles. The assertions also assume that `tick_us` is a strobe with no meaning beyond one cycle; the bench raises it for a single cycle and follows it with idle cycles. Register writes are issued only between tick steps, so a change of delay, width or enable never coincides with a tick that the bench is counting.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HIGH = 2'd2
  } seq_state_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_DELAY = 2'd1;
  localparam logic [1:0] ADDR_WIDTH = 2'd2;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SRC_BIT = 1;
  localparam int CTRL_IRQ_LSB = 2;
  localparam int IRQ_N        = 3;
endpackage

// File: rtl/tpg_sync_edge.sv
module tpg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], din};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3
endmodule

// File: rtl/tpg_regs.sv
module tpg_regs
  import tpg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              enable,
  output logic              src_ext,
  output logic [IRQ_N-1:0]  irq_en,
  output logic [DATA_W-1:0] delay,
  output logic [DATA_W-1:0] width
);
  localparam int CTRL_W = CTRL_IRQ_LSB + IRQ_N;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      delay  <= '0;
      width  <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_CTRL:  ctrl_q <= wdata[CTRL_W-1:0];
        ADDR_DELAY: delay  <= wdata;
        ADDR_WIDTH: width  <= wdata;
        default: ;
      endcase
    end
  end

  assign enable  = ctrl_q[CTRL_EN_BIT];
  assign src_ext = ctrl_q[CTRL_SRC_BIT];
  assign irq_en  = ctrl_q[CTRL_IRQ_LSB +: IRQ_N];

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_DELAY: rdata = delay;
      ADDR_WIDTH: rdata = width;
      default:    rdata = '0;
    endcase
  end

  AST_WRITE_DELAY_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_DELAY) |=> delay == $past(wdata)); // R2
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
  import tpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             trig_rise,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic [CNT_W-1:0] delay,
  input  logic [CNT_W-1:0] width,
  output logic             pulse_out,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pulse_out <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!enable) begin
        state     <= ST_IDLE;
        cnt       <= '0;
        pulse_out <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: if (trig_rise) begin
            state <= ST_WAIT;
            cnt   <= delay;
            irq   <= irq_en[0];
          end
          ST_WAIT: if (tick) begin
            if (cnt == '0) begin
              state     <= ST_HIGH;
              cnt       <= width;
              pulse_out <= 1'b1;
              irq       <= irq_en[1];
            end else begin
              cnt <= cnt - CNT_ONE;
            end
          end
          ST_HIGH: if (tick) begin
            if (cnt <= CNT_ONE) begin
              state     <= ST_IDLE;
              cnt       <= '0;
              pulse_out <= 1'b0;
              irq       <= irq_en[2];
            end else begin
              cnt <= cnt - CNT_ONE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == ST_IDLE && !pulse_out)); // R8
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> $past(tick)); // R3
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_out) |-> ($past(tick) || !$past(enable))); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !tick && enable) |=> $stable(cnt)); // R5
  AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && trig_rise && !tick && enable) |=> (state == ST_WAIT && $stable(cnt))); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_en) != '0); // R7
endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer
  import tpg_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_us,
  input  logic              trig_in,
  input  logic              ext_clk,
  output logic              pulse_out,
  output logic              irq
);
  logic             enable, src_ext, trig_rise, ext_rise, tick;
  logic [IRQ_N-1:0] irq_en;
  logic [DATA_W-1:0] delay, width;

  tpg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .enable(enable),
    .src_ext(src_ext), .irq_en(irq_en), .delay(delay), .width(width)
  );

  tpg_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_in), .rise(trig_rise)
  );

  tpg_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise)
  );

  assign tick = src_ext ? ext_rise : tick_us;

  tpg_seq #(.CNT_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .trig_rise(trig_rise), .irq_en(irq_en), .delay(delay), .width(width),
    .pulse_out(pulse_out), .irq(irq)
  );
endmodule

// File: tb/test_trig_pulse_timer.sv
`timescale 1ns/1ps
module test_trig_pulse_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tick_us = 1'b0;
  logic        trig_in = 1'b0;
  logic        ext_clk = 1'b0;
  logic        pulse_out, irq;

  int checks = 0;
  int fails = 0;
  int irq_total = 0;

  always #2.5 clk = ~clk;

  trig_pulse_timer i_trig_pulse_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_us(tick_us),
    .trig_in(trig_in), .ext_clk(ext_clk), .pulse_out(pulse_out), .irq(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_total++;

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  // row: delay[35:20], width[19:4], irq_en[3:1], src[0]
  localparam int NV = 6;
  localparam logic [35:0] VEC [0:NV-1] = '{
    {16'd0, 16'd0, 3'b111, 1'b0},
    {16'd2, 16'd3, 3'b001, 1'b0},
    {16'd5, 16'd1, 3'b010, 1'b1},
    {16'd1, 16'd4, 3'b100, 1'b1},
    {16'd3, 16'd0, 3'b110, 1'b0},
    {16'd0, 16'd2, 3'b000, 1'b1}
  };

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic fire_trig();
    @(negedge clk); trig_in = 1'b1;
    repeat (4) @(negedge clk);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic step_tick(input logic ext);
    if (!ext) begin
      @(negedge clk); tick_us = 1'b1;
      @(negedge clk); tick_us = 1'b0;
      repeat (2) @(negedge clk);
    end else begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  // counts ticks until the rise and then the ticks spent high
  task automatic measure(input logic ext, input int start, output int rise_n, output int high_n);
    int n = start;
    rise_n = -1; high_n = -1;
    for (int i = 0; i < 40 && rise_n < 0; i++) begin
      step_tick(ext); n++;
      if (pulse_out) rise_n = n;
    end
    n = 0;
    for (int i = 0; i < 40 && high_n < 0; i++) begin
      step_tick(ext); n++;
      if (!pulse_out) high_n = n;
    end
  endtask

  initial begin
    logic [15:0] rd;
    int r, h, base;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1 pulse_out", int'(pulse_out), 0);
    check_eq("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    reg_read(2'd0, rd); check_eq("R1 ctrl", int'(rd), 0);
    reg_read(2'd1, rd); check_eq("R1 delay", int'(rd), 0);

    // R2 register readback
    reg_write(2'd1, 16'h1234);
    reg_read(2'd1, rd); check_eq("R2 delay readback", int'(rd), 'h1234);
    reg_write(2'd2, 16'hBEEF);
    reg_read(2'd2, rd); check_eq("R2 width readback", int'(rd), 'hBEEF);
    reg_write(2'd0, 16'hFFE2);
    reg_read(2'd0, rd); check_eq("R2 ctrl readback", int'(rd), 'h02);
    reg_read(2'd3, rd); check_eq("R2 addr3 zero", int'(rd), 0);

    // R3 R4 R5 R7 vector table
    for (int v = 0; v < NV; v++) begin
      logic [15:0] d = VEC[v][35:20];
      logic [15:0] w = VEC[v][19:4];
      logic [2:0]  ie = VEC[v][3:1];
      logic        s = VEC[v][0];
      reg_write(2'd1, d);
      reg_write(2'd2, w);
      reg_write(2'd0, {11'd0, ie, s, 1'b1});
      base = irq_total;
      fire_trig();
      measure(s, 0, r, h);
      check_eq("R3 ticks to rise", r, int'(d) + 1);
      check_eq("R4 ticks high", h, (w == 0) ? 1 : int'(w));
      repeat (2) @(negedge clk);
      check_eq("R7 irq count", irq_total - base, $countones(ie));
    end

    // R6 retrigger during delay
    reg_write(2'd1, 16'd3);
    reg_write(2'd2, 16'd2);
    reg_write(2'd0, 16'h0005);
    base = irq_total;
    fire_trig();
    step_tick(1'b0);
    fire_trig();
    measure(1'b0, 1, r, h);
    check_eq("R6 rise unchanged by retrigger", r, 4);
    check_eq("R6 single trigger irq", irq_total - base, 1);

    // R5 tick_us ignored in external mode
    reg_write(2'd1, 16'd0);
    reg_write(2'd2, 16'd1);
    reg_write(2'd0, 16'h0003);
    fire_trig();
    for (int i = 0; i < 3; i++) step_tick(1'b0);
    check_eq("R5 tick_us ignored", int'(pulse_out), 0);
    step_tick(1'b1);
    check_eq("R5 ext edge advances", int'(pulse_out), 1);
    step_tick(1'b1);
    check_eq("R4 back low", int'(pulse_out), 0);

    // R8 disable mid-pulse, then triggers ignored while disabled
    reg_write(2'd2, 16'd5);
    reg_write(2'd0, 16'h001D);
    base = irq_total;
    fire_trig();
    step_tick(1'b0);
    check_eq("R8 pulse started", int'(pulse_out), 1);
    reg_write(2'd0, 16'h001C);
    repeat (2) @(negedge clk);
    check_eq("R8 output low after disable", int'(pulse_out), 0);
    check_eq("R8 no fall irq on disable", irq_total - base, 2);
    base = irq_total;
    fire_trig();
    for (int i = 0; i < 3; i++) step_tick(1'b0);
    check_eq("R8 disabled trigger no pulse", int'(pulse_out), 0);
    check_eq("R8 disabled trigger no irq", irq_total - base, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule